// File: doc/BRIEF.md
# Subsampling Windowed Readout Sequencer

This block walks one rectangular window of a 1920 x 1200 pixel array and issues one readout address per clock: a physical row select and the physical first column of an eight-pixel column group, one group for each of the eight parallel output lanes. The array carries four dummy lines on every side, so every visible coordinate is shifted by four. The block never addresses a dummy line while it reads a frame.

Software places a window configuration and a subsampling mode on the configuration inputs and pulses `start`. The block captures and clamps the configuration at that frame boundary. It then scans the window in row-major order, with the column groups in the inner loop. It can read every line, keep one line and drop one, or keep two adjacent lines and drop two. The same pattern applies to rows and to column groups. A pulse on `row_start` marks the first group of each row that is read. A pulse on `frame_start` marks the first group of the frame. `frame_done` follows the last group. The controller has three states. Idle waits for `start`. Scan issues one group per cycle and leaves for Done after the last group of the last row. Done lasts one cycle and returns to Idle.

Top module: `subsample_readout_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `out_valid`, `row_start`, `frame_start` and `frame_done` are all 0.
- R2: A `start` sampled high while the block is idle makes `busy` and `out_valid` high on the next cycle. That cycle carries the first group of the frame. One group is then issued every cycle until the frame ends.
- R3: `row_sel` equals 4 plus the visible row index. `col_addr` equals 4 plus 8 times the visible group index. Both stay inside the visible array whenever `out_valid` is high.
- R4: The window covers rows 2*`cfg_row_pair_first` through 2*(`cfg_row_pair_first`+`cfg_row_pair_count`)-1 and groups `cfg_grp_first` through `cfg_grp_first`+`cfg_grp_count`-1. It is scanned row by row, with groups in ascending order inside each row.
- R5: `cfg_mode` is a 2-bit code. Code 0 reads every line, and so does code 3. Code 1 reads only window offsets whose value is even. Code 2 reads only offsets whose value mod 4 is 0 or 1. The rule holds for both rows and groups, with offsets counted from the window start.
- R6: At capture, a group start above 239 is clamped to 239 and a row-pair start above 599 is clamped to 599. A count that runs past the array edge is cut to what remains, and a count of 0 becomes 1.
- R7: The configuration is captured only when a frame is started. Changing the configuration inputs during a frame has no effect on that frame. A `start` while `busy` is high starts no further frame.
- R8: `row_start` is high with the first group of every row that is read. `frame_start` is high only with the very first group of the frame.
- R9: `frame_done` is a single-cycle pulse in the cycle right after the last group. `busy` is 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one frame when idle |
| cfg_grp_first | input | 8 | Window first column group |
| cfg_grp_count | input | 8 | Window width in column groups |
| cfg_row_pair_first | input | 10 | Window first row pair |
| cfg_row_pair_count | input | 10 | Window height in row pairs |
| cfg_mode | input | 2 | Subsampling code (0/3 full, 1 keep-1-drop-1, 2 keep-2-drop-2) |
| busy | output | 1 | Frame in progress, including the done cycle |
| out_valid | output | 1 | A group address is issued this cycle |
| row_sel | output | 11 | Physical row address |
| col_addr | output | 11 | Physical first column of the group |
| row_start | output | 1 | First group of a row |
| frame_start | output | 1 | First group of the frame |
| frame_done | output | 1 | Frame finished |

## Verification
The first group appears one cycle after the edge that samples `start`. Each following group comes one cycle after the previous one, and `frame_done` comes one cycle after the last group. The driver task builds the full expected sequence from the clamped window and the mode rules, with the done marker queued last. The monitor samples on the falling edge and pops one entry for each cycle with `out_valid` or `frame_done`. Any gap, extra group or early done therefore shows up as a mismatch. Separate checks at fixed falling edges cover the one-cycle start latency, the idle state after done, and the case where a start during a frame is ignored.

// File: rtl/sro_pkg.sv
package sro_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } sro_state_t;

    typedef enum logic [1:0] {
        SUB_FULL = 2'd0,
        SUB_HALF = 2'd1,
        SUB_PAIR = 2'd2,
        SUB_RSVD = 2'd3
    } sro_mode_t;
endpackage

// File: rtl/sro_clamp.sv
module sro_clamp #(
    parameter int LIMIT = 240,
    parameter int W     = $clog2(LIMIT + 1)
) (
    input  logic [W-1:0] first_i,
    input  logic [W-1:0] count_i,
    output logic [W-1:0] first_o,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] LAST_IDX = W'(LIMIT - 1);
    localparam logic [W-1:0] LIM_W    = W'(LIMIT);

    logic [W-1:0] room;

    always_comb begin
        first_o = (first_i > LAST_IDX) ? LAST_IDX : first_i;
        room    = LIM_W - first_o;
        if (count_i == '0)
            count_o = W'(1);
        else if (count_i > room)
            count_o = room;
        else
            count_o = count_i;
    end
endmodule

// File: rtl/sro_step.sv
module sro_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] size,
    input  logic [1:0]   mode,
    output logic [W-1:0] nxt,
    output logic         last
);
    import sro_pkg::*;

    logic [W+1:0] wide;
    logic [2:0]   inc;

    always_comb begin
        unique case (sro_mode_t'(mode))
            SUB_HALF: inc = 3'd2;
            SUB_PAIR: inc = idx[0] ? 3'd3 : 3'd1;
            default:  inc = 3'd1;
        endcase
        wide = {2'b00, idx} + (W+2)'(inc);
        last = wide >= {2'b00, size};
        nxt  = wide[W-1:0];
    end
endmodule

// File: rtl/subsample_readout_seq.sv
module subsample_readout_seq #(
    parameter int COLS  = 1920,
    parameter int ROWS  = 1200,
    parameter int LANES = 8,
    parameter int DUMMY = 4,
    localparam int NGRP  = COLS / LANES,
    localparam int NPAIR = ROWS / 2,
    localparam int GW    = $clog2(NGRP + 1),
    localparam int PW    = $clog2(NPAIR + 1),
    localparam int RW    = $clog2(ROWS + 1),
    localparam int RAW   = $clog2(ROWS + 2 * DUMMY),
    localparam int CAW   = $clog2(COLS + 2 * DUMMY)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [GW-1:0]  cfg_grp_first,
    input  logic [GW-1:0]  cfg_grp_count,
    input  logic [PW-1:0]  cfg_row_pair_first,
    input  logic [PW-1:0]  cfg_row_pair_count,
    input  logic [1:0]     cfg_mode,
    output logic           busy,
    output logic           out_valid,
    output logic [RAW-1:0] row_sel,
    output logic [CAW-1:0] col_addr,
    output logic           row_start,
    output logic           frame_start,
    output logic           frame_done
);
    import sro_pkg::*;

    sro_state_t    state;
    logic [GW-1:0] lat_gf, lat_gc, cl_gf, cl_gc;
    logic [PW-1:0] lat_pf, lat_pc, cl_pf, cl_pc;
    logic [1:0]    lat_mode;
    logic [GW-1:0] k_col, col_nxt;
    logic [RW-1:0] k_row, row_nxt, row_size;
    logic          col_last, row_last;

    sro_clamp #(.LIMIT(NGRP), .W(GW)) u_clamp_col (
        .first_i(cfg_grp_first), .count_i(cfg_grp_count),
        .first_o(cl_gf),         .count_o(cl_gc)
    );

    sro_clamp #(.LIMIT(NPAIR), .W(PW)) u_clamp_row (
        .first_i(cfg_row_pair_first), .count_i(cfg_row_pair_count),
        .first_o(cl_pf),              .count_o(cl_pc)
    );

    assign row_size = RW'({lat_pc, 1'b0});

    sro_step #(.W(GW)) u_step_col (
        .idx(k_col), .size(lat_gc), .mode(lat_mode),
        .nxt(col_nxt), .last(col_last)
    );

    sro_step #(.W(RW)) u_step_row (
        .idx(k_row), .size(row_size), .mode(lat_mode),
        .nxt(row_nxt), .last(row_last)
    );

    // state register, counters and captured configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            k_col    <= '0;
            k_row    <= '0;
            lat_gf   <= '0;
            lat_gc   <= '0;
            lat_pf   <= '0;
            lat_pc   <= '0;
            lat_mode <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lat_gf   <= cl_gf;
                        lat_gc   <= cl_gc;
                        lat_pf   <= cl_pf;
                        lat_pc   <= cl_pc;
                        lat_mode <= cfg_mode;
                        k_col    <= '0;
                        k_row    <= '0;
                        state    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (col_last) begin
                        k_col <= '0;
                        if (row_last)
                            state <= ST_DONE;
                        else
                            k_row <= row_nxt;
                    end else begin
                        k_col <= col_nxt;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        out_valid   = (state == ST_SCAN);
        row_start   = out_valid && (k_col == '0);
        frame_start = row_start && (k_row == '0);
        frame_done  = (state == ST_DONE);
        row_sel     = RAW'(DUMMY) + RAW'({lat_pf, 1'b0}) + RAW'(k_row);
        col_addr    = CAW'(DUMMY) + CAW'(LANES) * (CAW'(lat_gf) + CAW'(k_col));
    end
endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
    parameter int ROWS  = 1200,
    parameter int COLS  = 1920,
    parameter int LANES = 8,
    parameter int DUMMY = 4,
    parameter int RAW   = 11,
    parameter int CAW   = 11
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           out_valid,
    input logic [RAW-1:0] row_sel,
    input logic [CAW-1:0] col_addr,
    input logic           row_start,
    input logic           frame_start,
    input logic           frame_done,
    input logic [1:0]     lat_mode
);
    assert_row_visible_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (row_sel >= RAW'(DUMMY)) && (row_sel < RAW'(DUMMY + ROWS)));

    assert_col_visible_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (col_addr >= CAW'(DUMMY)) && (col_addr < CAW'(DUMMY + COLS))
                      && (((col_addr - CAW'(DUMMY)) % CAW'(LANES)) == '0));

    assert_frame_start_first_R8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> row_start && out_valid);

    assert_start_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy && frame_start);

    assert_mode_held_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(lat_mode));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(out_valid) && !out_valid);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done && !busy);
endmodule

bind subsample_readout_seq sro_checker #(
    .ROWS(ROWS), .COLS(COLS), .LANES(LANES), .DUMMY(DUMMY), .RAW(RAW), .CAW(CAW)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .out_valid(out_valid),
    .row_sel(row_sel), .col_addr(col_addr), .row_start(row_start),
    .frame_start(frame_start), .frame_done(frame_done), .lat_mode(lat_mode)
);

// File: tb/subsample_readout_seq_tb.sv
module subsample_readout_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  cfg_grp_first = '0, cfg_grp_count = '0;
    logic [9:0]  cfg_row_pair_first = '0, cfg_row_pair_count = '0;
    logic [1:0]  cfg_mode = '0;
    logic        busy, out_valid, row_start, frame_start, frame_done;
    logic [10:0] row_sel, col_addr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [24:0] exp_q[$];
    logic prev_valid = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    subsample_readout_seq u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_grp_first(cfg_grp_first), .cfg_grp_count(cfg_grp_count),
        .cfg_row_pair_first(cfg_row_pair_first), .cfg_row_pair_count(cfg_row_pair_count),
        .cfg_mode(cfg_mode), .busy(busy), .out_valid(out_valid),
        .row_sel(row_sel), .col_addr(col_addr), .row_start(row_start),
        .frame_start(frame_start), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit keep(input int k, input int mode);
        if (mode == 1) return (k % 2) == 0;
        if (mode == 2) return (k % 4) < 2;
        return 1'b1;
    endfunction

    // item layout: [24] done, [23] row_start, [22] frame_start, [21:11] row, [10:0] col
    task automatic run_frame(input int gf, input int gc, input int pf, input int pc,
                             input int mode, input bit poke);
        int cgf, cgc, cpf, cpc;
        bit first_row;
        cgf = (gf > 239) ? 239 : gf;
        cgc = (gc == 0) ? 1 : ((gc > 240 - cgf) ? 240 - cgf : gc);
        cpf = (pf > 599) ? 599 : pf;
        cpc = (pc == 0) ? 1 : ((pc > 600 - cpf) ? 600 - cpf : pc);
        first_row = 1'b1;
        for (int r = 0; r < 2 * cpc; r++) begin
            if (!keep(r, mode)) continue;
            for (int c = 0; c < cgc; c++) begin
                logic [24:0] it;
                if (!keep(c, mode)) continue;
                it = {1'b0, (c == 0), (c == 0 && first_row),
                      11'(4 + 2 * cpf + r), 11'(4 + 8 * (cgf + c))};
                exp_q.push_back(it);
            end
            first_row = 1'b0;
        end
        exp_q.push_back({1'b1, 24'd0});
        @(negedge clk);
        cfg_grp_first = 8'(gf); cfg_grp_count = 8'(gc);
        cfg_row_pair_first = 10'(pf); cfg_row_pair_count = 10'(pc);
        cfg_mode = 2'(mode);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && out_valid, "R2 start latency", {busy, out_valid}, 3);
        if (poke) begin
            cfg_grp_first = 8'd7; cfg_grp_count = 8'd9; cfg_mode = 2'd0;
            cfg_row_pair_first = 10'd3; cfg_row_pair_count = 10'd5;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(!busy && !out_valid, "R7 R9 idle after frame", {busy, out_valid}, 0);
        check(exp_q.size() == 0, "R4 all groups issued", exp_q.size(), 0);
        exp_q.delete();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid || frame_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 R7 unexpected output", {out_valid, frame_done}, 0);
                end else begin
                    logic [24:0] e;
                    e = exp_q.pop_front();
                    if (e[24]) begin
                        check(frame_done && !out_valid && prev_valid, "R9 done pulse",
                              {frame_done, out_valid, prev_valid}, 5);
                    end else begin
                        check(out_valid && !frame_done, "R2 group issued",
                              {out_valid, frame_done}, 2);
                        check(row_sel == e[21:11], "R3 R4 R5 R6 row address",
                              row_sel, e[21:11]);
                        check(col_addr == e[10:0], "R3 R4 R5 R6 column address",
                              col_addr, e[10:0]);
                        check({row_start, frame_start} == e[23:22], "R8 row/frame start",
                              {row_start, frame_start}, e[23:22]);
                    end
                end
            end
            prev_valid <= out_valid;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !out_valid && !row_start && !frame_start && !frame_done,
              "R1 reset outputs", {busy, out_valid, row_start, frame_start, frame_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !out_valid && !frame_done, "R1 after reset",
              {busy, out_valid, frame_done}, 0);
        run_frame(2, 3, 1, 2, 0, 1'b0);    // R4 full window
        run_frame(5, 7, 0, 4, 1, 1'b0);    // R5 keep one, drop one
        run_frame(10, 9, 3, 5, 2, 1'b0);   // R5 keep two, drop two
        run_frame(0, 4, 0, 2, 3, 1'b0);    // R5 code 3 reads all
        run_frame(250, 5, 700, 3, 0, 1'b0);// R6 starts beyond array
        run_frame(236, 9, 597, 8, 1, 1'b0);// R6 counts cut at edge
        run_frame(4, 0, 2, 0, 2, 1'b0);    // R6 zero counts
        run_frame(1, 6, 2, 3, 2, 1'b1);    // R7 changes during frame
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule